// File: doc/BRIEF.md
# Raster Video Interrupt Controller

This block collects the interrupt sources of a video display engine and presents them to a processor through a byte-wide register port. It has four sources: the vertical sync event, a match between the running scanline and a programmable compare line, a sprite collision event with its 4-bit collision group mask, and a level input that is high while the audio sample buffer is below one quarter full. Each source has a status flag and an enable bit. The single interrupt output is high while any flag is set together with its enable bit.

The scanline counter, the collision detector and the audio buffer sit outside the block. They drive it with single-cycle event pulses, a collision mask and a buffer-low level. The register port has three byte offsets. 0x06 holds the enables, and its two spare upper bits carry the ninth bit of each 9-bit line value. 0x07 holds the status flags and the captured collision mask. 0x08 reads the current scanline, but a write to it loads the compare line. Writes take effect on the clock edge. Reads are combinational from the addressed offset.

Top module: `rvic_top`

## Requirements
- R1: After reset, every enable, every status flag, the collision mask and the compare line are zero, and `irq_o` is low.
- R2: Bits 3..0 of offset 0x06 are written and read back as the enables for vsync (bit 0), raster line (bit 1), sprite collision (bit 2) and audio buffer low (bit 3). Bit 7 of 0x06 always reads 0, and bits 5..4 read 0.
- R3: A `vsync_evt_i` pulse sets status bit 0 of offset 0x07 on the next clock edge, whatever the state of its enable bit.
- R4: Writing 0x07 with a 1 in bit 0, 1 or 2 clears that status flag. A 0 in those bit positions leaves the flag unchanged.
- R5: Status bit 3 is high in the cycle after each edge at which `abuf_low_i` is high, and low in the cycle after each edge at which it is low. Writes to 0x07 have no effect on it.
- R6: A `sprcol_evt_i` pulse sets status bit 2 and captures `sprcol_grp_i` into status bits 7..4. The mask holds its value until the next collision event and is not cleared when bit 2 is cleared.
- R7: Reading offset 0x08 returns bits 7..0 of `scanline_i`, and bit 6 of offset 0x06 reads as `scanline_i[8]`. Writing 0x08 loads compare-line bits 7..0, and bit 7 of a write to 0x06 loads compare-line bit 8.
- R8: Status bit 1 is set on the first clock at which the 9-bit scanline equals the 9-bit compare line. While the equality continues it is not set again.
- R9: `irq_o` is high exactly when some status bit 0..3 and the matching enable bit are both 1.
- R10: If an event for status bit 0, 1 or 2 arrives in the same cycle as a write-1-to-clear of that bit, the bit ends up set.

Top module parameters: `ADDR_W` (default 8), `SET_WINS` (default 1). Data width is fixed at 8, the line width at 9 and the mask width at 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| scanline_i | input | 9 | Current scanline from the raster counter |
| vsync_evt_i | input | 1 | Vertical sync event pulse |
| sprcol_evt_i | input | 1 | Sprite collision event pulse |
| sprcol_grp_i | input | 4 | Collision group mask, valid with the pulse |
| abuf_low_i | input | 1 | Audio buffer below one quarter full |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that `vsync_evt_i` and `sprcol_evt_i` are synchronous to `clk`, that `sprcol_grp_i` is valid in the cycle of the collision pulse, and that `scanline_i` changes only on clock edges. They also assume a write strobe lasts one cycle. The bench drives every input on the falling edge, so each value is stable across the rising edge that samples it. It holds the scanline away from the compare line during reset, so no line event appears before the line test begins.

// File: rtl/rvic_pkg.sv
package rvic_pkg;
   localparam int DATA_W   = 8;
   localparam int SCAN_W   = 9;
   localparam int SRC_N    = 4;
   localparam int GRP_W    = 4;

   localparam int SRC_VS   = 0;
   localparam int SRC_LINE = 1;
   localparam int SRC_SPR  = 2;
   localparam int SRC_ABUF = 3;

   localparam int OFS_EN   = 6;
   localparam int OFS_STAT = 7;
   localparam int OFS_LINE = 8;

   localparam int EN_SCAN_HI_BIT = 6;
   localparam int EN_CMP_HI_BIT  = 7;

   typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/rvic_line_match.sv
module rvic_line_match #(
   parameter int SCAN_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SCAN_W-1:0] scan,
   input  logic [SCAN_W-1:0] cmp,
   output logic              evt
);
   logic match;
   logic match_q;

   assign match = (scan == cmp);

   always_ff @(posedge clk) begin
      if (!rst_n) match_q <= 1'b0;
      else        match_q <= match;
   end

   // one-cycle pulse when equality begins
   assign evt = match & ~match_q;
endmodule

// File: rtl/rvic_flags.sv
module rvic_flags #(
   parameter int SRC_N    = 4,
   parameter int GRP_W    = 4,
   parameter int LVL_IDX  = 3,
   parameter bit SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_N-1:0] ev,
   input  logic [SRC_N-1:0] clr,
   input  logic             grp_evt,
   input  logic [GRP_W-1:0] grp_in,
   output logic [SRC_N-1:0] flags,
   output logic [GRP_W-1:0] grp
);
   if (LVL_IDX >= SRC_N) begin : g_bad_lvl
      $error("LVL_IDX out of range");
   end

   for (genvar i = 0; i < SRC_N; i++) begin : g_src
      if (i == LVL_IDX) begin : g_level
         // follows the source level; software cannot clear it
         always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= ev[i];
         end
      end else if (SET_WINS) begin : g_set_pri
         always_ff @(posedge clk) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (ev[i])  flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
         end
      end else begin : g_clr_pri
         always_ff @(posedge clk) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (clr[i]) flags[i] <= 1'b0;
            else if (ev[i])  flags[i] <= 1'b1;
         end
      end
   end

   logic unused_lvl_clr;
   assign unused_lvl_clr = clr[LVL_IDX];

   always_ff @(posedge clk) begin
      if (!rst_n)       grp <= '0;
      else if (grp_evt) grp <= grp_in;
   end
endmodule

// File: rtl/rvic_regs.sv
module rvic_regs
   import rvic_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [SCAN_W-1:0] scan,
   input  logic [SRC_N-1:0]  flags,
   input  logic [GRP_W-1:0]  grp,
   output logic [SRC_N-1:0]  en,
   output logic [SCAN_W-1:0] cmp_line,
   output logic [SRC_N-1:0]  clr,
   output logic [DATA_W-1:0] rdata
);
   localparam int PAD_W = EN_SCAN_HI_BIT - SRC_N;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must reach offset 8");
   end
   if (PAD_W < 0) begin : g_bad_pad
      $error("enable field overlaps scanline bit");
   end

   logic sel_en, sel_stat, sel_line;
   assign sel_en   = (bus_addr == ADDR_W'(OFS_EN));
   assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
   assign sel_line = (bus_addr == ADDR_W'(OFS_LINE));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en       <= '0;
         cmp_line <= '0;
      end else if (bus_wen) begin
         if (sel_en) begin
            en                   <= bus_wdata[SRC_N-1:0];
            cmp_line[SCAN_W-1]   <= bus_wdata[EN_CMP_HI_BIT];
         end
         if (sel_line)
            cmp_line[DATA_W-1:0] <= bus_wdata;
      end
   end

   // write-1-to-clear strobes; the level source ignores its bit downstream
   assign clr = (bus_wen && sel_stat) ? bus_wdata[SRC_N-1:0] : '0;

   logic unused_wbits;
   assign unused_wbits = ^bus_wdata[EN_SCAN_HI_BIT:SRC_N];

   always_comb begin
      rdata = '0;
      if (sel_en)
         rdata = {1'b0, scan[SCAN_W-1], {PAD_W{1'b0}}, en};
      else if (sel_stat)
         rdata = {grp, flags};
      else if (sel_line)
         rdata = scan[DATA_W-1:0];
   end
endmodule

// File: rtl/rvic_top.sv
module rvic_top
   import rvic_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [8:0]        scanline_i,
   input  logic              vsync_evt_i,
   input  logic              sprcol_evt_i,
   input  logic [3:0]        sprcol_grp_i,
   input  logic              abuf_low_i,
   output logic              irq_o
);
   if (SCAN_W != DATA_W + 1) begin : g_bad_scan
      $error("line width must be one more than data width");
   end
   if (GRP_W + SRC_N != DATA_W) begin : g_bad_stat
      $error("status byte must hold flags and mask");
   end

   src_vec_t           en, clr, ev, flags;
   logic [SCAN_W-1:0]  cmp_line;
   logic [GRP_W-1:0]   grp;
   logic               line_evt;

   rvic_line_match #(.SCAN_W(SCAN_W)) u_match (
      .clk   (clk),
      .rst_n (rst_n),
      .scan  (scanline_i),
      .cmp   (cmp_line),
      .evt   (line_evt)
   );

   always_comb begin
      ev           = '0;
      ev[SRC_VS]   = vsync_evt_i;
      ev[SRC_LINE] = line_evt;
      ev[SRC_SPR]  = sprcol_evt_i;
      ev[SRC_ABUF] = abuf_low_i;
   end

   rvic_flags #(
      .SRC_N    (SRC_N),
      .GRP_W    (GRP_W),
      .LVL_IDX  (SRC_ABUF),
      .SET_WINS (SET_WINS)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev      (ev),
      .clr     (clr),
      .grp_evt (sprcol_evt_i),
      .grp_in  (sprcol_grp_i),
      .flags   (flags),
      .grp     (grp)
   );

   rvic_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wen   (bus_wen),
      .bus_wdata (bus_wdata),
      .scan      (scanline_i),
      .flags     (flags),
      .grp       (grp),
      .en        (en),
      .cmp_line  (cmp_line),
      .clr       (clr),
      .rdata     (bus_rdata)
   );

   assign irq_o = |(flags & en);
endmodule

// File: rtl/rvic_chk.sv
module rvic_chk #(
   parameter int ADDR_W   = 8,
   parameter bit SET_WINS = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wen,
   input logic [7:0]        bus_wdata,
   input logic [8:0]        scanline_i,
   input logic [8:0]        cmp_line,
   input logic              vsync_evt_i,
   input logic              sprcol_evt_i,
   input logic [3:0]        sprcol_grp_i,
   input logic              abuf_low_i,
   input logic              line_evt,
   input logic [3:0]        flags,
   input logic [3:0]        grp,
   input logic [3:0]        en,
   input logic              irq_o
);
   logic stat_wr;
   assign stat_wr = bus_wen && (bus_addr == ADDR_W'(7));

   // R3
   if (SET_WINS) begin : g_setwins
      // R10
      vsync_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         vsync_evt_i |=> flags[0]);
   end

   // R4
   line_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && bus_wdata[1] && !line_evt) |=> !flags[1]);

   // R4
   keep_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[0] && stat_wr && !bus_wdata[0]) |=> flags[0]);

   // R5
   abuf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abuf_low_i |=> flags[3]);

   // R5
   abuf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !abuf_low_i |=> !flags[3]);

   // R6
   grp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sprcol_evt_i |=> (grp == $past(sprcol_grp_i)));

   // R8
   line_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[1]) |-> ($past(scanline_i) == $past(cmp_line)));

   // R9
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en == 4'h0) |-> !irq_o);
endmodule

bind rvic_top rvic_chk #(.ADDR_W(ADDR_W), .SET_WINS(SET_WINS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_addr     (bus_addr),
   .bus_wen      (bus_wen),
   .bus_wdata    (bus_wdata),
   .scanline_i   (scanline_i),
   .cmp_line     (cmp_line),
   .vsync_evt_i  (vsync_evt_i),
   .sprcol_evt_i (sprcol_evt_i),
   .sprcol_grp_i (sprcol_grp_i),
   .abuf_low_i   (abuf_low_i),
   .line_evt     (line_evt),
   .flags        (flags),
   .grp          (grp),
   .en           (en),
   .irq_o        (irq_o)
);

// File: tb/rvic_top_tb.sv
module rvic_top_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] bus_addr;
   logic       bus_wen;
   logic [7:0] bus_wdata;
   logic [7:0] bus_rdata;
   logic [8:0] scanline_i;
   logic       vsync_evt_i, sprcol_evt_i, abuf_low_i;
   logic [3:0] sprcol_grp_i;
   logic       irq_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   rvic_top u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scanline_i(scanline_i),
      .vsync_evt_i(vsync_evt_i), .sprcol_evt_i(sprcol_evt_i),
      .sprcol_grp_i(sprcol_grp_i), .abuf_low_i(abuf_low_i), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic t_reset();
      rd("R1 enables", 8'h06, 8'h00);
      rd("R1 status", 8'h07, 8'h00);
      check("R1 irq", {7'd0, irq_o}, 8'h00);
   endtask

   task automatic t_enable();
      wr(8'h06, 8'h3F);
      rd("R2 enable readback", 8'h06, 8'h0F);
      scanline_i = 9'h155;
      step();
      rd("R7 scanline bit8 in 0x06", 8'h06, 8'h4F);
      rd("R7 scanline low read", 8'h08, 8'h55);
      wr(8'h06, 8'h00);
      rd("R2 enables cleared", 8'h06, 8'h40);
   endtask

   task automatic t_vsync();
      vsync_evt_i = 1'b1; step(); vsync_evt_i = 1'b0;
      rd("R3 vsync flag with enable off", 8'h07, 8'h01);
      check("R9 irq masked", {7'd0, irq_o}, 8'h00);
      wr(8'h06, 8'h01);
      check("R9 irq enabled", {7'd0, irq_o}, 8'h01);
      wr(8'h07, 8'h00);
      rd("R4 zero write keeps flag", 8'h07, 8'h01);
      wr(8'h07, 8'h01);
      rd("R4 w1c clears vsync", 8'h07, 8'h00);
      check("R9 irq drops", {7'd0, irq_o}, 8'h00);
   endtask

   task automatic t_setwins();
      bus_addr = 8'h07; bus_wdata = 8'h01; bus_wen = 1'b1; vsync_evt_i = 1'b1;
      step();
      bus_wen = 1'b0; vsync_evt_i = 1'b0;
      rd("R10 set beats clear", 8'h07, 8'h01);
      wr(8'h07, 8'h01);
      wr(8'h06, 8'h00);
   endtask

   task automatic t_sprcol();
      sprcol_grp_i = 4'hA; sprcol_evt_i = 1'b1; step();
      sprcol_evt_i = 1'b0; sprcol_grp_i = 4'h5;
      rd("R6 collision flag and mask", 8'h07, 8'hA4);
      wr(8'h07, 8'h04);
      rd("R6 mask kept after clear", 8'h07, 8'hA0);
   endtask

   task automatic t_abuf();
      abuf_low_i = 1'b1; step();
      rd("R5 buffer low flag", 8'h07, 8'hA8);
      wr(8'h07, 8'h0F);
      rd("R5 write cannot clear", 8'h07, 8'hA8);
      wr(8'h06, 8'h08);
      check("R9 irq from buffer", {7'd0, irq_o}, 8'h01);
      abuf_low_i = 1'b0; step();
      rd("R5 flag follows level", 8'h07, 8'hA0);
      check("R9 irq after buffer refill", {7'd0, irq_o}, 8'h00);
   endtask

   task automatic t_line();
      wr(8'h06, 8'h80);
      wr(8'h08, 8'h23);
      rd("R8 no match yet", 8'h07, 8'hA0);
      scanline_i = 9'h123; step();
      rd("R7 R8 match on 9-bit line", 8'h07, 8'hA2);
      wr(8'h07, 8'h02);
      step(); step(); step();
      rd("R8 no re-set while equal", 8'h07, 8'hA0);
      scanline_i = 9'h124; step();
      scanline_i = 9'h123; step();
      rd("R8 new match sets again", 8'h07, 8'hA2);
      wr(8'h06, 8'h82);
      check("R9 irq from line", {7'd0, irq_o}, 8'h01);
      scanline_i = 9'h023; step();
      rd("R7 low byte alone is no match", 8'h07, 8'hA2);
   endtask

   initial begin
      rst_n = 1'b0; bus_addr = 8'h00; bus_wen = 1'b0; bus_wdata = 8'h00;
      scanline_i = 9'h064; vsync_evt_i = 1'b0; sprcol_evt_i = 1'b0;
      sprcol_grp_i = 4'h0; abuf_low_i = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_enable();
      t_vsync();
      t_setwins();
      t_sprcol();
      t_abuf();
      wr(8'h07, 8'h02);
      t_line();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule